// File: doc/BRIEF.md
# Dual Page Buffer Engine

This block keeps two 256-byte scratch buffers inside a flash device model. One buffer is current at any time, and a single page bit selects it. The command interpreter forwards every bus write to the block with a flag that marks the opcode byte of a new command. The block then decodes its own commands from those writes: load one byte, stream a counted run of bytes, swap buffers, and stamp a fixed signature record and then swap. The page bit is an output so that the global status byte can report it. A read port returns the current buffer's byte at any offset, combinationally.

Programming buffer contents into the flash array is left to the interpreter. The signature record carries a size code and a 48-bit serial number, and both are parameters.

Top module: `page_buffer_engine`

## Requirements
- R1: After reset, `page_bit` is 0 and `cmd_fail` is 0. Buffer contents are undefined.
- R2: `rd_data` shows the byte at offset `rd_addr` of the buffer selected by `page_bit`, in the same cycle. Every store goes only to that buffer, and the other buffer keeps its bytes.
- R3: An opcode byte 0x72 inverts `page_bit` at the next clock edge and changes no buffer byte.
- R4: Opcode 0x74 followed by one more write stores that write's data at that write's `req_addr`, and then the engine goes idle.
- R5: Opcode 0xE0 is followed by two count bytes, low byte first, taken from the data of the next two writes whatever their addresses are. Each later write stores its data at its address, and the stream ends after count+1 stores. A write after the last store changes nothing.
- R6: A sequential load with count 0 stores exactly one byte.
- R7: Opcode 0x38 followed by a write with data 0xD0 writes a record into the current buffer and then inverts `page_bit`. The record is 0x4D at offset 0x00, 0x50 at 0x02, 0x04 at 0x04, and {4'h1, size code} at 0x06. The serial bytes go most significant first at 0x08, 0x0A, 0x0C, 0x0E, 0x10 and 0x12. Odd offsets are not touched.
- R8: Opcode 0x38 followed by any byte other than 0xD0 raises `cmd_fail` for exactly one cycle. It modifies no buffer and leaves `page_bit` unchanged, and later non-opcode writes are ignored.
- R9: After any other opcode, non-opcode writes store nothing and leave `page_bit` unchanged.
- R10: An opcode write in the middle of a sequential load ends the stream and starts the new command.
- R11: A store to the offset on the read port shows the old byte until the clock edge that performs the store, and the new byte after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A bus write is presented this cycle |
| req_first | input | 1 | The write is a command's opcode byte |
| req_addr | input | PAGE_AW | Low address bits of the write |
| req_data | input | 8 | Data byte of the write |
| rd_addr | input | PAGE_AW | Offset to read in the current buffer |
| rd_data | output | 8 | Byte at `rd_addr` in the current buffer |
| page_bit | output | 1 | Current buffer select, bit 0 of global status |
| cmd_fail | output | 1 | One-cycle pulse on a rejected signature confirm |

## Verification
A read of an offset and a store to that same offset can happen in the same cycle. The bench provokes this by holding `rd_addr` on the target while the second byte of a single load is driven. It samples before the edge and expects the old byte, then samples after the edge and expects the new one. The signature stamp and the swap also share one edge. To check them, the bench swaps back and reads the record from the buffer that was current when the confirm byte arrived.

// File: rtl/page_buffer_engine.sv
module page_buffer_engine #(
  parameter int          PAGE_AW       = 8,
  parameter int          SIZE_KIB_LOG2 = 10,
  parameter logic [47:0] SERIAL        = 48'h0000_0123_4567
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_first,
  input  logic [PAGE_AW-1:0] req_addr,
  input  logic [7:0]         req_data,
  input  logic [PAGE_AW-1:0] rd_addr,
  output logic [7:0]         rd_data,
  output logic               page_bit,
  output logic               cmd_fail
);
  localparam int DEPTH = 1 << PAGE_AW;
  localparam int CNT_W = 16;
  localparam logic [7:0] OP_LOAD = 8'h74, OP_STREAM = 8'hE0, OP_SIGN = 8'h38,
                         OP_SWAP = 8'h72, CONFIRM = 8'hD0;
  localparam logic [7:0] SIZE_BYTE = {4'h1, 4'(SIZE_KIB_LOG2)};

  typedef enum logic [2:0] {IDLE, LOAD, CNT_LO, CNT_HI, STREAM, SIGN} state_t;

  state_t           state;
  logic [CNT_W-1:0] remain;
  logic [7:0]       mem [2][DEPTH];

  wire opcode   = req_valid && req_first;
  wire operand  = req_valid && !req_first;
  wire store_en = operand && (state == LOAD || state == STREAM);
  wire sign_ok  = operand && state == SIGN && req_data == CONFIRM;

  assign rd_data = mem[page_bit][rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= IDLE;
      remain   <= '0;
      page_bit <= 1'b0;
      cmd_fail <= 1'b0;
    end else begin
      cmd_fail <= 1'b0;
      if (opcode) begin
        case (req_data)
          OP_LOAD:   state <= LOAD;
          OP_STREAM: state <= CNT_LO;
          OP_SIGN:   state <= SIGN;
          OP_SWAP: begin
            page_bit <= ~page_bit;
            state    <= IDLE;
          end
          default:   state <= IDLE;
        endcase
      end else if (operand) begin
        case (state)
          CNT_LO: begin
            remain[7:0] <= req_data;
            state       <= CNT_HI;
          end
          CNT_HI: begin
            remain[15:8] <= req_data;
            state        <= STREAM;
          end
          STREAM: begin
            if (remain == '0) state <= IDLE;
            else remain <= remain - 1'b1;
          end
          SIGN: begin
            if (req_data == CONFIRM) page_bit <= ~page_bit;
            else cmd_fail <= 1'b1;
            state <= IDLE;
          end
          default: state <= IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (store_en) mem[page_bit][req_addr] <= req_data;
    if (sign_ok) begin
      mem[page_bit][PAGE_AW'(8'h00)] <= 8'h4D;
      mem[page_bit][PAGE_AW'(8'h02)] <= 8'h50;
      mem[page_bit][PAGE_AW'(8'h04)] <= 8'h04;
      mem[page_bit][PAGE_AW'(8'h06)] <= SIZE_BYTE;
      mem[page_bit][PAGE_AW'(8'h08)] <= SERIAL[47:40];
      mem[page_bit][PAGE_AW'(8'h0A)] <= SERIAL[39:32];
      mem[page_bit][PAGE_AW'(8'h0C)] <= SERIAL[31:24];
      mem[page_bit][PAGE_AW'(8'h0E)] <= SERIAL[23:16];
      mem[page_bit][PAGE_AW'(8'h10)] <= SERIAL[15:8];
      mem[page_bit][PAGE_AW'(8'h12)] <= SERIAL[7:0];
    end
  end
endmodule

// File: rtl/page_buffer_engine_chk.sv
module page_buffer_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_first,
  input logic [7:0] req_data,
  input logic       page_bit,
  input logic       cmd_fail
);
  // R1
  reset_page_chk: assert property (@(posedge clk) !rst_n |=> !page_bit && !cmd_fail);

  // R3
  swap_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_first && req_data == 8'h72 |=> page_bit != $past(page_bit));

  // R9
  page_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(page_bit));

  // R8
  fail_keeps_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fail |-> $stable(page_bit) && $past(req_valid && !req_first && req_data != 8'hD0));

  // R8
  fail_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fail |=> !cmd_fail);
endmodule

bind page_buffer_engine page_buffer_engine_chk u_chk (.*);

// File: tb/page_buffer_engine_bench.sv
module page_buffer_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       req_valid = 1'b0, req_first = 1'b0;
  logic [7:0] req_addr = '0, req_data = '0, rd_addr = '0;
  logic [7:0] rd_data;
  logic       page_bit, cmd_fail;
  int checks = 0, failures = 0;

  page_buffer_engine u_page_buffer_engine (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input bit first, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_first = first; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0; req_first = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic put(input logic [7:0] a, input logic [7:0] d);
    wr(1, 8'h00, 8'h74); wr(0, a, d);
  endtask

  task automatic expect_byte(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v); check(req, v, exp);
  endtask

  task automatic t_reset;
    check("R1 page", {7'd0, page_bit}, 8'h00);
    check("R1 fail", {7'd0, cmd_fail}, 8'h00);
  endtask

  task automatic t_single;
    put(8'h10, 8'hA5);
    expect_byte("R4 single", 8'h10, 8'hA5);
    wr(0, 8'h10, 8'h00);
    expect_byte("R4 idle after load", 8'h10, 8'hA5);
  endtask

  task automatic t_swap;
    logic p;
    p = page_bit;
    wr(1, 8'h00, 8'h72);
    check("R3 swap", {7'd0, page_bit}, {7'd0, ~p});
    put(8'h10, 8'h3C);
    wr(1, 8'h00, 8'h72);
    expect_byte("R2 other buffer kept", 8'h10, 8'hA5);
    wr(1, 8'h00, 8'h72);
    expect_byte("R3 contents kept", 8'h10, 8'h3C);
    wr(1, 8'h00, 8'h72);
  endtask

  task automatic t_stream;
    wr(1, 8'h00, 8'hE0);
    wr(0, 8'h01, 8'h00);
    wr(0, 8'h00, 8'h01);
    for (int i = 0; i <= 256; i++) wr(0, 8'(i), 8'(i) ^ 8'h5A);
    expect_byte("R5 last wraps", 8'h00, 8'h5A);
    expect_byte("R5 second", 8'h01, 8'h5B);
    expect_byte("R5 top", 8'hFF, 8'hA5);
    wr(0, 8'h01, 8'h00);
    expect_byte("R5 after end", 8'h01, 8'h5B);
  endtask

  task automatic t_stream0;
    put(8'h31, 8'h55);
    wr(1, 8'h00, 8'hE0); wr(0, 8'h00, 8'h00); wr(0, 8'h00, 8'h00);
    wr(0, 8'h30, 8'h9C);
    wr(0, 8'h31, 8'h00);
    expect_byte("R6 one store", 8'h30, 8'h9C);
    expect_byte("R6 no second", 8'h31, 8'h55);
  endtask

  task automatic t_abort;
    logic p;
    put(8'h42, 8'h66);
    wr(1, 8'h00, 8'hE0); wr(0, 8'h00, 8'h05); wr(0, 8'h00, 8'h00);
    wr(0, 8'h40, 8'h01); wr(0, 8'h41, 8'h02);
    p = page_bit;
    wr(1, 8'h00, 8'h72);
    check("R10 new cmd runs", {7'd0, page_bit}, {7'd0, ~p});
    wr(1, 8'h00, 8'h72);
    wr(0, 8'h42, 8'h00);
    expect_byte("R10 stream ended", 8'h42, 8'h66);
    expect_byte("R10 early store", 8'h41, 8'h02);
  endtask

  task automatic t_sign;
    logic p;
    put(8'h01, 8'hC1); put(8'h03, 8'hC3); put(8'h13, 8'hC7);
    p = page_bit;
    wr(1, 8'h00, 8'h38); wr(0, 8'h00, 8'hD0);
    check("R7 swap", {7'd0, page_bit}, {7'd0, ~p});
    check("R7 no fail", {7'd0, cmd_fail}, 8'h00);
    wr(1, 8'h00, 8'h72);
    expect_byte("R7 00", 8'h00, 8'h4D);
    expect_byte("R7 02", 8'h02, 8'h50);
    expect_byte("R7 04", 8'h04, 8'h04);
    expect_byte("R7 06", 8'h06, 8'h1A);
    expect_byte("R7 08", 8'h08, 8'h00);
    expect_byte("R7 0A", 8'h0A, 8'h00);
    expect_byte("R7 0C", 8'h0C, 8'h01);
    expect_byte("R7 0E", 8'h0E, 8'h23);
    expect_byte("R7 10", 8'h10, 8'h45);
    expect_byte("R7 12", 8'h12, 8'h67);
    expect_byte("R7 odd 01", 8'h01, 8'hC1);
    expect_byte("R7 odd 03", 8'h03, 8'hC3);
    expect_byte("R7 odd 13", 8'h13, 8'hC7);
  endtask

  task automatic t_sign_bad;
    logic p;
    put(8'h00, 8'hAA);
    p = page_bit;
    wr(1, 8'h00, 8'h38); wr(0, 8'h00, 8'hD1);
    check("R8 fail pulse", {7'd0, cmd_fail}, 8'h01);
    check("R8 page kept", {7'd0, page_bit}, {7'd0, p});
    expect_byte("R8 no write", 8'h00, 8'hAA);
    @(negedge clk);
    check("R8 pulse ends", {7'd0, cmd_fail}, 8'h00);
    wr(0, 8'h00, 8'hD0);
    check("R8 late confirm", {7'd0, page_bit}, {7'd0, p});
    expect_byte("R8 late no write", 8'h00, 8'hAA);
  endtask

  task automatic t_unknown;
    logic p;
    put(8'h05, 8'h12);
    p = page_bit;
    wr(1, 8'h00, 8'h90); wr(0, 8'h05, 8'hEE);
    expect_byte("R9 ignored", 8'h05, 8'h12);
    check("R9 page", {7'd0, page_bit}, {7'd0, p});
  endtask

  task automatic t_same_cycle;
    put(8'h60, 8'h11);
    wr(1, 8'h00, 8'h74);
    @(negedge clk);
    req_valid = 1'b1; req_first = 1'b0; req_addr = 8'h60; req_data = 8'h5A;
    rd_addr = 8'h60; #1;
    check("R11 old before edge", rd_data, 8'h11);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check("R11 new after edge", rd_data, 8'h5A);
    check("R2 read port", rd_data, 8'h5A);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_single;
    t_swap;
    t_stream;
    t_stream0;
    t_abort;
    t_sign;
    t_sign_bad;
    t_unknown;
    t_same_cycle;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule